// File: doc/BRIEF.md
# Vector Carry-Less Multiply Unit

This execution unit carries out carry-less (polynomial, XOR-accumulated) multiplication on 64-bit vector elements. A command carries a 32-bit instruction word, a scalar operand, the vector length, a start index and a mask word. The unit decodes the word and checks whether it may run. It then walks the element indices from the start index up to the vector length minus one. For each index it takes one beat of source operands and returns one beat of result. The instruction chooses whether the result is the low or the high 64 bits of the 128-bit product. It also chooses whether the second operand comes from the vector stream or is the scalar, repeated for every element.

Operands and results move on valid/ready streams. A source beat moves when `in_valid` and `in_ready` are both high at a clock edge. A result beat moves when `out_valid` and `out_ready` are both high. The consumer may hold `out_ready` low for as long as it likes. While it does, the unit keeps the same beat on `out_data`/`out_idx` and takes no further source beats. The producer may hold `in_valid` low, and the unit simply waits. Each source beat also carries the current destination value. An element that is masked off returns that value unchanged, so the destination is left undisturbed. Indices at or past the vector length are never emitted, so the destination keeps them as they were.

A parameter selects how the product is formed: in a single cycle, or over 64 cycles at one multiplier bit per cycle. Both give the same results; only the latency differs.

Top module: `vclmul_unit`

## Requirements
- R1: For the low-half operation (bits 31:26 = 001100) each active element's result is the XOR, over every set bit j of the vs2 operand y, of the other operand x shifted left by j, truncated to 64 bits.
- R2: For the high-half operation (bits 31:26 = 001101) each active element's result is the XOR, over every set bit j from 1 to 63 of y, of x shifted right by 64−j. Bit 0 of y has no effect on the result.
- R3: Bits 14:12 = 010 take x from the `in_vs1` stream. Bits 14:12 = 110 take x from `cmd_scalar` for every element and ignore `in_vs1`. Equal operands give equal results in both forms.
- R4: A command is recognised only with bits 6:0 = 1010111, bits 31:26 of 001100 or 001101, and bits 14:12 of 010 or 110. Any other word ends at once with `done` and `illegal` high and emits no result beat.
- R5: `sew_sel` = 3'b011 selects 64-bit elements. Any other value makes the command illegal: `done` and `illegal` are high one cycle after it is accepted, and no result beat is emitted.
- R6: With `cfg_elen64_en` low every command is illegal, with the same behaviour as in R5.
- R7: When instruction bit 25 is 0, element i is active only if `cmd_mask[i]` is 1. An inactive element still takes its source beat but returns `in_old` as its result. When bit 25 is 1, every element is active.
- R8: Result beats are emitted once per index, in ascending order, from `cmd_vstart` to vl−1, where vl is `cmd_vl` clamped to VLMAX. If `cmd_vstart` ≥ vl, the command ends with `done` high, `illegal` low and no beats.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_idx` stay unchanged in the next cycle.
- R10: `done` is a one-cycle pulse. It comes in the cycle after the last result beat is accepted, or in the cycle after an illegal or empty command is accepted. `illegal` is high only together with `done`.
- R11: `cmd_ready` is high only while no command is in progress. After reset `cmd_ready` is 1 and `in_ready`, `out_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_elen64_en | input | 1 | 64-bit element support enabled |
| sew_sel | input | 3 | Selected element width, 3'b011 = 64 bits |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command may be taken |
| cmd_instr | input | 32 | Instruction word |
| cmd_scalar | input | 64 | Scalar operand for the vector-scalar form |
| cmd_vl | input | 6 | Vector length |
| cmd_vstart | input | 6 | First element index |
| cmd_mask | input | 32 | Per-element mask bits |
| in_valid | input | 1 | Source beat offered |
| in_ready | output | 1 | Unit takes a source beat |
| in_vs2 | input | 64 | Operand y for the current element |
| in_vs1 | input | 64 | Operand x for the current element (vector-vector form) |
| in_old | input | 64 | Current destination value for the element |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result beat |
| out_data | output | 64 | Result or undisturbed old value |
| out_idx | output | 6 | Element index of the result beat |
| done | output | 1 | Command finished (one-cycle pulse) |
| illegal | output | 1 | Command rejected, valid with `done` |

## Verification
Some properties are checked on every cycle. The result beat stays stable under back-pressure. `done` lasts a single cycle and `illegal` only comes with it. Commands with a wrong element width or with the configuration disabled are rejected. No index is emitted outside the range from the start index to the length. A new command is never offered as ready while a stream is in progress. Other behaviour shows only in the bench's scenarios, through its own reference products. These are the exact low-half and high-half products, scalar broadcast, mask pass-through of old values, ascending index order, and the rejection of malformed opcode or function fields.

// File: rtl/vclmul_pkg.sv
package vclmul_pkg;
  localparam logic [6:0] OPC_VEC = 7'b1010111;
  localparam logic [5:0] F6_LO   = 6'b001100;
  localparam logic [5:0] F6_HI   = 6'b001101;
  localparam logic [2:0] F3_VV   = 3'b010;
  localparam logic [2:0] F3_VX   = 3'b110;
  localparam logic [2:0] SEW_64  = 3'b011;

  typedef struct packed {
    logic legal;
    logic hi;
    logic vx;
    logic unmasked;
  } vcl_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CALC,
    ST_EMIT,
    ST_FIN
  } vcl_state_t;
endpackage

// File: rtl/vclmul_decode.sv
module vclmul_decode
  import vclmul_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [2:0]  sew_sel,
  input  logic        cfg_en,
  output vcl_op_t     op
);
  logic [5:0] f6;
  logic [2:0] f3;
  logic [6:0] opc;
  logic       f6_ok, f3_ok;

  assign f6  = instr[31:26];
  assign f3  = instr[14:12];
  assign opc = instr[6:0];

  always_comb begin
    f6_ok       = (f6 == F6_LO) || (f6 == F6_HI);
    f3_ok       = (f3 == F3_VV) || (f3 == F3_VX);
    op.legal    = (opc == OPC_VEC) && f6_ok && f3_ok && cfg_en && (sew_sel == SEW_64);
    op.hi       = (f6 == F6_HI);
    op.vx       = (f3 == F3_VX);
    op.unmasked = instr[25];
  end
endmodule

// File: rtl/vclmul_core.sv
module vclmul_core #(
  parameter int W      = 64,
  parameter bit SERIAL = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W);

  generate
    if (!SERIAL) begin : g_comb
      function automatic logic [PW-1:0] full_clmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [PW-1:0] acc;
        acc = '0;
        for (int j = 0; j < W; j++) begin
          if (b[j]) acc = acc ^ ({{W{1'b0}}, a} << j);
        end
        return acc;
      endfunction

      logic [PW-1:0] prod_q;
      logic          done_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q <= '0;
          done_q <= 1'b0;
        end else begin
          done_q <= start;
          if (start) prod_q <= full_clmul(x, y);
        end
      end

      assign prod = prod_q;
      assign done = done_q;
    end else begin : g_serial
      logic [PW-1:0] xs_q, acc_q;
      logic [W-1:0]  ys_q;
      logic [CW-1:0] cnt_q;
      logic          busy_q, done_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          xs_q   <= '0;
          acc_q  <= '0;
          ys_q   <= '0;
          cnt_q  <= '0;
          busy_q <= 1'b0;
          done_q <= 1'b0;
        end else begin
          done_q <= 1'b0;
          if (start) begin
            xs_q   <= {{W{1'b0}}, x};
            ys_q   <= y;
            acc_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
          end else if (busy_q) begin
            if (ys_q[0]) acc_q <= acc_q ^ xs_q;
            xs_q  <= xs_q << 1;
            ys_q  <= ys_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(W - 1)) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end

      assign prod = acc_q;
      assign done = done_q;
    end
  endgenerate
endmodule

// File: rtl/vclmul_seq.sv
module vclmul_seq
  import vclmul_pkg::*;
#(
  parameter int W     = 64,
  parameter int VLMAX = 32,
  parameter int IDXW  = $clog2(VLMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  vcl_op_t         op,
  input  logic [W-1:0]    cmd_scalar,
  input  logic [IDXW-1:0] cmd_vl,
  input  logic [IDXW-1:0] cmd_vstart,
  input  logic [VLMAX-1:0] cmd_mask,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_vs2,
  input  logic [W-1:0]    in_vs1,
  input  logic [W-1:0]    in_old,
  output logic            core_start,
  output logic [W-1:0]    core_x,
  output logic [W-1:0]    core_y,
  input  logic            core_done,
  input  logic [2*W-1:0]  core_prod,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_data,
  output logic [IDXW-1:0] out_idx,
  output logic            done,
  output logic            illegal
);
  localparam int MIW = $clog2(VLMAX);

  vcl_state_t      state_q;
  vcl_op_t         op_q;
  logic [W-1:0]    scalar_q, res_q;
  logic [IDXW-1:0] vl_q, idx_q, vl_eff, idx_nxt;
  logic [VLMAX-1:0] mask_q;
  logic            ill_q, elem_active;

  assign vl_eff      = (cmd_vl > IDXW'(VLMAX)) ? IDXW'(VLMAX) : cmd_vl;
  assign idx_nxt     = idx_q + 1'b1;
  assign elem_active = op_q.unmasked || mask_q[idx_q[MIW-1:0]];

  assign cmd_ready  = (state_q == ST_IDLE);
  assign in_ready   = (state_q == ST_FETCH);
  assign out_valid  = (state_q == ST_EMIT);
  assign done       = (state_q == ST_FIN);
  assign illegal    = (state_q == ST_FIN) && ill_q;
  assign out_data   = res_q;
  assign out_idx    = idx_q;

  assign core_start = (state_q == ST_FETCH) && in_valid && elem_active;
  assign core_y     = in_vs2;
  assign core_x     = op_q.vx ? scalar_q : in_vs1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      scalar_q <= '0;
      res_q    <= '0;
      vl_q     <= '0;
      idx_q    <= '0;
      mask_q   <= '0;
      ill_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q     <= op;
            scalar_q <= cmd_scalar;
            vl_q     <= vl_eff;
            mask_q   <= cmd_mask;
            idx_q    <= cmd_vstart;
            if (!op.legal) begin
              ill_q   <= 1'b1;
              state_q <= ST_FIN;
            end else if (cmd_vstart >= vl_eff) begin
              ill_q   <= 1'b0;
              state_q <= ST_FIN;
            end else begin
              ill_q   <= 1'b0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (in_valid) begin
            if (elem_active) begin
              state_q <= ST_CALC;
            end else begin
              res_q   <= in_old;
              state_q <= ST_EMIT;
            end
          end
        end
        ST_CALC: begin
          if (core_done) begin
            res_q   <= op_q.hi ? core_prod[2*W-1:W] : core_prod[W-1:0];
            state_q <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (idx_nxt == vl_q) begin
              state_q <= ST_FIN;
            end else begin
              idx_q   <= idx_nxt;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vclmul_unit.sv
module vclmul_unit
  import vclmul_pkg::*;
#(
  parameter int W      = 64,
  parameter int VLMAX  = 32,
  parameter bit SERIAL = 1'b0,
  localparam int IDXW  = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_elen64_en,
  input  logic [2:0]       sew_sel,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_instr,
  input  logic [W-1:0]     cmd_scalar,
  input  logic [IDXW-1:0]  cmd_vl,
  input  logic [IDXW-1:0]  cmd_vstart,
  input  logic [VLMAX-1:0] cmd_mask,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_vs2,
  input  logic [W-1:0]     in_vs1,
  input  logic [W-1:0]     in_old,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic [IDXW-1:0]  out_idx,
  output logic             done,
  output logic             illegal
);
  vcl_op_t        dec_op;
  logic           core_start, core_done;
  logic [W-1:0]   core_x, core_y;
  logic [2*W-1:0] core_prod;

  vclmul_decode u_dec (
    .instr   (cmd_instr),
    .sew_sel (sew_sel),
    .cfg_en  (cfg_elen64_en),
    .op      (dec_op)
  );

  vclmul_core #(.W(W), .SERIAL(SERIAL)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .start (core_start),
    .x     (core_x),
    .y     (core_y),
    .done  (core_done),
    .prod  (core_prod)
  );

  vclmul_seq #(.W(W), .VLMAX(VLMAX), .IDXW(IDXW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .op         (dec_op),
    .cmd_scalar (cmd_scalar),
    .cmd_vl     (cmd_vl),
    .cmd_vstart (cmd_vstart),
    .cmd_mask   (cmd_mask),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_vs2     (in_vs2),
    .in_vs1     (in_vs1),
    .in_old     (in_old),
    .core_start (core_start),
    .core_x     (core_x),
    .core_y     (core_y),
    .core_done  (core_done),
    .core_prod  (core_prod),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_idx    (out_idx),
    .done       (done),
    .illegal    (illegal)
  );
endmodule

// File: rtl/vclmul_unit_chk.sv
module vclmul_unit_chk #(
  parameter int W     = 64,
  parameter int VLMAX = 32,
  parameter int IDXW  = $clog2(VLMAX + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_elen64_en,
  input logic [2:0]      sew_sel,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [IDXW-1:0] cmd_vl,
  input logic [IDXW-1:0] cmd_vstart,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_data,
  input logic [IDXW-1:0] out_idx,
  input logic            done,
  input logic            illegal
);
  logic [IDXW-1:0] vl_seen, vs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_seen <= '0;
      vs_seen <= '0;
    end else if (cmd_valid && cmd_ready) begin
      vl_seen <= (cmd_vl > IDXW'(VLMAX)) ? IDXW'(VLMAX) : cmd_vl;
      vs_seen <= cmd_vstart;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx)));

  // R10
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  sew_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (sew_sel != 3'b011)) |=> (illegal && !out_valid));

  // R6
  cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cfg_elen64_en) |=> (illegal && !out_valid));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_idx < vl_seen) && (out_idx >= vs_seen)));

  // R11
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || in_ready || done) |-> !cmd_ready);
endmodule

bind vclmul_unit vclmul_unit_chk #(.W(W), .VLMAX(VLMAX), .IDXW(IDXW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_elen64_en (cfg_elen64_en),
  .sew_sel       (sew_sel),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_vl        (cmd_vl),
  .cmd_vstart    (cmd_vstart),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_idx       (out_idx),
  .done          (done),
  .illegal       (illegal)
);

// File: tb/vclmul_unit_bench.sv
`timescale 1ns/1ps
module vclmul_unit_bench;
  localparam int VLMAX = 32;
  localparam int IDXW  = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_elen64_en = 1'b1;
  logic [2:0]       sew_sel = 3'b011;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [31:0]      cmd_instr = '0;
  logic [63:0]      cmd_scalar = '0;
  logic [IDXW-1:0]  cmd_vl = '0;
  logic [IDXW-1:0]  cmd_vstart = '0;
  logic [VLMAX-1:0] cmd_mask = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [63:0]      in_vs2 = '0, in_vs1 = '0, in_old = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [63:0]      out_data;
  logic [IDXW-1:0]  out_idx;
  logic             done, illegal;

  int checks = 0;
  int errors = 0;

  logic [63:0] a_vs2 [VLMAX];
  logic [63:0] a_vs1 [VLMAX];
  logic [63:0] a_old [VLMAX];
  logic [63:0] a_exp [VLMAX];

  always #4 clk = ~clk;

  vclmul_unit u_vclmul_unit (
    .clk(clk), .rst_n(rst_n), .cfg_elen64_en(cfg_elen64_en), .sew_sel(sew_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_instr(cmd_instr),
    .cmd_scalar(cmd_scalar), .cmd_vl(cmd_vl), .cmd_vstart(cmd_vstart), .cmd_mask(cmd_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_vs2(in_vs2), .in_vs1(in_vs1), .in_old(in_old),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_idx(out_idx),
    .done(done), .illegal(illegal)
  );

  function automatic logic [63:0] ref_lo(input logic [63:0] y, input logic [63:0] x);
    logic [63:0] r = '0;
    for (int j = 0; j < 64; j++) if (y[j]) r ^= (x << j);
    return r;
  endfunction

  function automatic logic [63:0] ref_hi(input logic [63:0] y, input logic [63:0] x);
    logic [63:0] r = '0;
    for (int j = 1; j < 64; j++) if (y[j]) r ^= (x >> (64 - j));
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] f6, input logic vm, input logic [2:0] f3,
                                     input logic [6:0] opc);
    return {f6, vm, 5'd8, 5'd4, f3, 5'd2, opc};
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic feeder(input int vs, input int vl);
    int i = vs;
    while (i < vl) begin
      @(negedge clk);
      in_valid = ($urandom_range(0, 3) != 0);
      in_vs2 = a_vs2[i];
      in_vs1 = a_vs1[i];
      in_old = a_old[i];
      #1;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collector(input int vs, input int vl, input string tag);
    int k = vs;
    bit held = 1'b0;
    logic [63:0] hd = '0;
    logic [IDXW-1:0] hi_idx = '0;
    while (k < vl) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 2) != 0);
      #1;
      if (held && out_valid)
        chk((out_data == hd) && (out_idx == hi_idx), "R9 held beat", out_data, hd);
      held = 1'b0;
      if (out_valid && out_ready) begin
        // R8 index order, R1/R2/R3/R7 data
        chk(out_idx == IDXW'(k), {tag, " R8 index"}, 64'(out_idx), 64'(k));
        chk(out_data == a_exp[k], tag, out_data, a_exp[k]);
        k++;
      end else if (out_valid) begin
        held = 1'b1;
        hd = out_data;
        hi_idx = out_idx;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(done && !illegal, "R10 done after last beat", {62'd0, done, illegal}, 64'd2);
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [2:0] sew, input logic en,
                        input logic [63:0] sc, input int vl, input int vs,
                        input logic [31:0] msk, input bit exp_ill, input string tag);
    int vle = (vl > VLMAX) ? VLMAX : vl;
    bit hi = ins[26];
    bit vx = ins[14];
    bit vm = ins[25];
    for (int i = 0; i < VLMAX; i++) begin
      logic [63:0] x = vx ? sc : a_vs1[i];
      if (vm || msk[i]) a_exp[i] = hi ? ref_hi(a_vs2[i], x) : ref_lo(a_vs2[i], x);
      else a_exp[i] = a_old[i];
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_instr = ins; sew_sel = sew; cfg_elen64_en = en;
    cmd_scalar = sc; cmd_vl = IDXW'(vl); cmd_vstart = IDXW'(vs); cmd_mask = msk;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (exp_ill || vs >= vle) begin
      #1;
      chk(done && (illegal == exp_ill) && !out_valid, {tag, " R4 end without beats"},
          {61'd0, done, illegal, out_valid}, {61'd0, 1'b1, exp_ill, 1'b0});
    end else begin
      fork
        feeder(vs, vle);
        collector(vs, vle, tag);
      join
    end
  endtask

  task automatic fill_rand();
    for (int i = 0; i < VLMAX; i++) begin
      a_vs2[i] = rnd64();
      a_vs1[i] = rnd64();
      a_old[i] = rnd64();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmd_ready && !in_ready && !out_valid && !done, "R11 reset",
        {60'd0, cmd_ready, in_ready, out_valid, done}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 corners
    fill_rand();
    a_vs2[0] = '1; a_vs1[0] = '1;
    a_vs2[1] = 64'd1; a_vs1[1] = 64'hdead_beef_0123_4567;
    a_vs2[2] = '0;
    a_vs2[3] = 64'h8000_0000_0000_0000; a_vs1[3] = 64'h3;
    run_op(mk(6'b001100, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 4, 0, 0, 0, "R1 low vv");

    // R2 corners: y bit0 only gives zero high half
    a_vs2[0] = 64'd1; a_vs1[0] = '1;
    a_vs2[1] = '1;    a_vs1[1] = '1;
    a_vs2[2] = 64'h8000_0000_0000_0000; a_vs1[2] = 64'h8000_0000_0000_0001;
    chk(ref_hi(64'd1, '1) == 64'd0, "R2 model bit0", ref_hi(64'd1, '1), 0);
    run_op(mk(6'b001101, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 4, 0, 0, 0, "R2 high vv");

    // R3 scalar broadcast; vs1 stream is ignored
    fill_rand();
    run_op(mk(6'b001100, 1'b1, 3'b110, 7'b1010111), 3'b011, 1'b1, 64'h0123_4567_89ab_cdef,
           8, 0, 0, 0, "R3 low vx");
    run_op(mk(6'b001101, 1'b1, 3'b110, 7'b1010111), 3'b011, 1'b1, 64'hf0f0_0000_1234_ffff,
           8, 0, 0, 0, "R3 high vx");

    // R7 masking, R8 vstart offset
    fill_rand();
    run_op(mk(6'b001100, 1'b0, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 12, 3,
           32'h0000_0a5c, 0, "R7 masked low");
    run_op(mk(6'b001101, 1'b0, 3'b110, 7'b1010111), 3'b011, 1'b1, rnd64(), 32, 0,
           32'h0000_0000, 0, "R7 all masked off");

    // R8 empty and clamped lengths
    run_op(mk(6'b001100, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 5, 5, 0, 0, "R8 empty");
    run_op(mk(6'b001100, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 40, 30, 0, 0, "R8 clamp");

    // R4/R5/R6 illegal commands
    run_op(mk(6'b001100, 1'b1, 3'b010, 7'b1010111), 3'b010, 1'b1, 0, 4, 0, 0, 1, "R5 sew32");
    run_op(mk(6'b001101, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b0, 0, 4, 0, 0, 1, "R6 cfg off");
    run_op(mk(6'b001110, 1'b1, 3'b010, 7'b1010111), 3'b011, 1'b1, 0, 4, 0, 0, 1, "R4 bad f6");
    run_op(mk(6'b001100, 1'b1, 3'b011, 7'b1010111), 3'b011, 1'b1, 0, 4, 0, 0, 1, "R4 bad f3");
    run_op(mk(6'b001100, 1'b1, 3'b010, 7'b0110011), 3'b011, 1'b1, 0, 4, 0, 0, 1, "R4 bad opc");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [5:0] f6 = $urandom_range(0, 1) ? 6'b001101 : 6'b001100;
      logic [2:0] f3 = $urandom_range(0, 1) ? 3'b110 : 3'b010;
      logic [2:0] sw = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 2)) : 3'b011;
      int vl = $urandom_range(0, 32);
      int vs = $urandom_range(0, 8);
      fill_rand();
      run_op(mk(f6, 1'($urandom_range(0, 1)), f3, 7'b1010111), sw, 1'b1, rnd64(), vl, vs,
             $urandom(), (sw != 3'b011), "R1 R2 R3 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule